// File: doc/BRIEF.md
# Multi-Depth Pixel Unpacker

This block sits between a framebuffer fetch path and a palette or colour pipeline. It takes 32-bit framebuffer words from a valid/ready stream and splits each word into pixels, one pixel per cycle, on a second valid/ready stream. The pixel-depth code sets how many pixels a word holds. Two ordering controls set where each pixel sits in the word. Depths of 8 bits and below give a palette index. Deeper depths give an 8:8:8 colour.

For colour output, a red/blue swap control and a 2-bit format input from the board decide the field layout of 16-bit data. A parameter selects between the base variant and the extended variant. The base variant has six depth codes and uses the board input for 16-bit data. The extended variant names its 16-bit layouts directly in the depth code. A combinational output gives the number of bytes in one line for the configured line width.

Top module: `pixel_unpacker`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A word is taken (`in_valid` and `in_ready` both high at a clock edge) only when no pixel of the previous word is still pending. Its first pixel is presented in the next cycle. Each edge with `out_valid` and `out_ready` both high advances to the next pixel. While `out_ready` is low, the pixel and its flag hold.
- R3: The pixel container width by depth code is 0→1, 1→2, 2→4, 3→8, 5→32 bits, and 16 bits for codes 4, 6 and 7. A word yields 32/width pixels. After the last pixel is taken, `out_valid` drops and `in_ready` rises.
- R4: When both ordering controls are clear, pixel i is taken from bits [i*w +: w] of the word, where w is the container width.
- R5: When `cfg_be_byte` is set, pixel i is taken from bits [32-(i+1)*w +: w], whatever the value of `cfg_be_pix`.
- R6: When only `cfg_be_pix` is set, pixels narrower than 8 bits are taken byte by byte from byte 0 upward, and from the MSB downward inside each byte. Pixels of 8 bits or more are placed as in R4.
- R7: Codes 0 to 3 give `out_is_index`=1 and `out_pixel` = the field zero-extended to 24 bits.
- R8: Direct colour drives `out_pixel[23:16]`=red, `[15:8]`=green and `[7:0]`=blue. With no swap, red comes from the lowest field of the pixel, green from the middle field and blue from the highest field. The field layouts are: 5551 = 5/5/5 bits at [4:0]/[9:5]/[14:10], with bit 15 ignored; 565 = [4:0]/[10:5]/[15:11]; 444 = [3:0]/[7:4]/[11:8]; 888 = [7:0]/[15:8]/[23:16], with [31:24] ignored. Each field is shifted left into 8 bits and the low bits are filled with zeros.
- R9: When `cfg_bgr` is set, red and blue are exchanged in direct-colour output. Exception: in the base variant, mux value 3 at code 4 forces the swap (see R10).
- R10: In the base variant at code 4, `fmt_mux`=1 selects 5551 with the swap given by `cfg_bgr`. `fmt_mux`=3 selects 565 with the swap always on. `fmt_mux`=0 or 2 selects 565 with the swap given by `cfg_bgr`.
- R11: In the extended variant, code 4 is 5551, code 6 is 565 and code 7 is 444, and `fmt_mux` has no effect. In the base variant, codes 6 and 7 behave exactly as code 4.
- R12: `line_bytes` is width/8, width/4, width/2 or width for codes 0 to 3, width*4 for code 5, and width*2 for codes 4, 6 and 7 (integer division).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_depth | input | 3 | Pixel-depth code |
| cfg_be_byte | input | 1 | Take pixels from the word MSB downward |
| cfg_be_pix | input | 1 | Order pixels from the MSB inside each byte |
| cfg_bgr | input | 1 | Exchange red and blue |
| fmt_mux | input | 2 | Board-level 16-bit format select (base variant) |
| cfg_width | input | WIDTH_W | Line width in pixels |
| line_bytes | output | WIDTH_W+2 | Bytes per line |
| in_valid | input | 1 | Word available |
| in_ready | output | 1 | Word can be taken |
| in_word | input | 32 | Framebuffer word |
| out_valid | output | 1 | Pixel available |
| out_ready | input | 1 | Pixel consumer ready |
| out_pixel | output | 24 | Palette index or RGB colour |
| out_is_index | output | 1 | Pixel is a palette index |

## Verification
The failures to look for are these. A wrong pixel counter shows at the ports as a word that ends one pixel early or late, so `in_ready` returns in the wrong cycle. A wrong bit position shows on the first pixel of a word, in the cycle right after the word is taken. A wrong format or swap decision shows as swapped or shifted colour channels on the very first direct-colour pixel. The sweep covers every depth code, every ordering combination, both swap values and all four mux values, on both variants side by side, so that an error in any one of them differs from the arithmetic model within one word.

// File: rtl/pu_pkg.sv
package pu_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 5;

  typedef enum logic [2:0] {
    FMT_INDEX = 3'd0,
    FMT_5551  = 3'd1,
    FMT_565   = 3'd2,
    FMT_444   = 3'd3,
    FMT_888   = 3'd4
  } fmt_e;

  typedef struct packed {
    fmt_e fmt;
    logic swap;
  } decode_t;

  // container width in bits for a depth code
  function automatic logic [5:0] cont_bits(input logic [2:0] code);
    case (code)
      3'd0: return 6'd1;
      3'd1: return 6'd2;
      3'd2: return 6'd4;
      3'd3: return 6'd8;
      3'd5: return 6'd32;
      default: return 6'd16;
    endcase
  endfunction

  // index of the last pixel in a word
  function automatic logic [IDX_W-1:0] last_index(input logic [2:0] code);
    case (code)
      3'd0: return 5'd31;
      3'd1: return 5'd15;
      3'd2: return 5'd7;
      3'd3: return 5'd3;
      3'd5: return 5'd0;
      default: return 5'd1;
    endcase
  endfunction

  // lowest bit position of pixel idx inside the word
  function automatic logic [IDX_W-1:0] bit_pos(input logic [2:0] code, input logic be_byte,
                                               input logic be_pix, input logic [IDX_W-1:0] idx);
    int b;
    int p;
    int pos;
    b = int'(cont_bits(code));
    p = int'(idx) * b;
    if (be_byte)
      pos = WORD_W - b - p;
    else if (be_pix && b < 8)
      pos = (p & ~7) + (8 - b) - (p & 7);
    else
      pos = p;
    return pos[IDX_W-1:0];
  endfunction

  // format and swap selection
  function automatic decode_t pick_fmt(input logic ext, input logic [2:0] code,
                                       input logic [1:0] mux, input logic bgr);
    decode_t d;
    d.swap = bgr;
    if (code <= 3'd3)      d.fmt = FMT_INDEX;
    else if (code == 3'd5) d.fmt = FMT_888;
    else if (ext) begin
      case (code)
        3'd6:    d.fmt = FMT_565;
        3'd7:    d.fmt = FMT_444;
        default: d.fmt = FMT_5551;
      endcase
    end else begin
      case (mux)
        2'd1:    d.fmt = FMT_5551;
        2'd3:    begin d.fmt = FMT_565; d.swap = 1'b1; end
        default: d.fmt = FMT_565;
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/pu_word_hold.sv
module pu_word_hold
  import pu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] word_q,
  output logic [IDX_W-1:0]  idx_q
);
  logic busy;
  logic word_take;
  logic pix_take;
  logic word_done;

  assign in_ready  = !busy;
  assign out_valid = busy;
  assign word_take = in_valid && in_ready;
  assign pix_take  = out_valid && out_ready;
  assign word_done = pix_take && (idx_q == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx_q  <= '0;
      word_q <= '0;
    end else if (word_take) begin
      busy   <= 1'b1;
      idx_q  <= '0;
      word_q <= in_word;
    end else if (word_done) begin
      busy   <= 1'b0;
    end else if (pix_take) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    word_take |=> (out_valid && idx_q == '0));
  a_r2_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(idx_q) && $stable(word_q)));
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_take && !word_done) |=> (idx_q == $past(idx_q) + 1'b1));
  a_r3_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (in_ready && !out_valid));
  a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (idx_q <= last_idx));
endmodule

// File: rtl/pu_extract.sv
module pu_extract
  import pu_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  pos,
  input  logic [5:0]        bits,
  output logic [WORD_W-1:0] field
);
  logic [WORD_W:0]   mask;
  logic [WORD_W-1:0] shifted;

  always_comb begin
    mask    = (33'd1 << bits) - 33'd1;
    shifted = word >> pos;
    field   = shifted & mask[WORD_W-1:0];
  end
endmodule

// File: rtl/pu_color.sv
module pu_color
  import pu_pkg::*;
(
  input  logic [23:0] field,
  input  decode_t     dec,
  output logic [23:0] pixel,
  output logic        is_index
);
  logic [7:0] c0, c1, c2;

  always_comb begin
    c0 = '0; c1 = '0; c2 = '0;
    case (dec.fmt)
      FMT_5551: begin
        c0 = {field[4:0], 3'b0};   c1 = {field[9:5], 3'b0};  c2 = {field[14:10], 3'b0};
      end
      FMT_565: begin
        c0 = {field[4:0], 3'b0};   c1 = {field[10:5], 2'b0}; c2 = {field[15:11], 3'b0};
      end
      FMT_444: begin
        c0 = {field[3:0], 4'b0};   c1 = {field[7:4], 4'b0};  c2 = {field[11:8], 4'b0};
      end
      FMT_888: begin
        c0 = field[7:0];           c1 = field[15:8];         c2 = field[23:16];
      end
      default: ;
    endcase
    is_index = (dec.fmt == FMT_INDEX);
    if (is_index)      pixel = {16'b0, field[7:0]};
    else if (dec.swap) pixel = {c2, c1, c0};
    else               pixel = {c0, c1, c2};
  end
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
  import pu_pkg::*;
#(
  parameter bit EXTENDED = 1'b0,
  parameter int WIDTH_W  = 12,
  localparam int LB_W    = WIDTH_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         cfg_depth,
  input  logic               cfg_be_byte,
  input  logic               cfg_be_pix,
  input  logic               cfg_bgr,
  input  logic [1:0]         fmt_mux,
  input  logic [WIDTH_W-1:0] cfg_width,
  output logic [LB_W-1:0]    line_bytes,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_word,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [23:0]        out_pixel,
  output logic               out_is_index
);
  logic [2:0]        eff_code;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  pix_pos;
  logic [WORD_W-1:0] field;
  logic              unused_hi;
  decode_t           dec;

  // base variant folds the extended-only codes onto code 4
  assign eff_code  = (!EXTENDED && cfg_depth[2:1] == 2'b11) ? 3'd4 : cfg_depth;
  assign pix_pos   = bit_pos(eff_code, cfg_be_byte, cfg_be_pix, idx_q);
  assign dec       = pick_fmt(EXTENDED, eff_code, fmt_mux, cfg_bgr);
  assign unused_hi = ^field[WORD_W-1:24];

  always_comb begin
    case (eff_code)
      3'd0:    line_bytes = LB_W'(cfg_width >> 3);
      3'd1:    line_bytes = LB_W'(cfg_width >> 2);
      3'd2:    line_bytes = LB_W'(cfg_width >> 1);
      3'd3:    line_bytes = LB_W'(cfg_width);
      3'd5:    line_bytes = {cfg_width, 2'b00};
      default: line_bytes = {1'b0, cfg_width, 1'b0};
    endcase
  end

  pu_word_hold u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .last_idx(last_index(eff_code)), .out_ready(out_ready),
    .out_valid(out_valid), .word_q(word_q), .idx_q(idx_q)
  );

  pu_extract u_extract (
    .word(word_q), .pos(pix_pos), .bits(cont_bits(eff_code)), .field(field)
  );

  pu_color u_color (
    .field(field[23:0]), .dec(dec), .pixel(out_pixel), .is_index(out_is_index)
  );

  a_r7_index_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_index) |-> (out_pixel[23:8] == 16'b0));
  a_r7_index_by_depth: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_is_index == (cfg_depth <= 3'd3)));
  a_r12_bytes_8bpp: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_depth == 3'd3) |-> (line_bytes == LB_W'(cfg_width)));
  a_r2_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
endmodule

// File: tb/pixel_unpacker_bench.sv
module pixel_unpacker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH_W    = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cfg_depth = '0;
  logic cfg_be_byte = 1'b0, cfg_be_pix = 1'b0, cfg_bgr = 1'b0;
  logic [1:0] fmt_mux = '0;
  logic [WIDTH_W-1:0] cfg_width = '0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [31:0] in_word = '0;

  logic [WIDTH_W+1:0] lb_b, lb_x;
  logic rdy_b, rdy_x, ov_b, ov_x, ix_b, ix_x;
  logic [23:0] px_b, px_x;

  int applied = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_unpacker #(.EXTENDED(1'b0), .WIDTH_W(WIDTH_W)) u_pixel_unpacker (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_be_byte(cfg_be_byte),
    .cfg_be_pix(cfg_be_pix), .cfg_bgr(cfg_bgr), .fmt_mux(fmt_mux), .cfg_width(cfg_width),
    .line_bytes(lb_b), .in_valid(in_valid), .in_ready(rdy_b), .in_word(in_word),
    .out_valid(ov_b), .out_ready(out_ready), .out_pixel(px_b), .out_is_index(ix_b));

  pixel_unpacker #(.EXTENDED(1'b1), .WIDTH_W(WIDTH_W)) u_pixel_unpacker_x (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_be_byte(cfg_be_byte),
    .cfg_be_pix(cfg_be_pix), .cfg_bgr(cfg_bgr), .fmt_mux(fmt_mux), .cfg_width(cfg_width),
    .line_bytes(lb_x), .in_valid(in_valid), .in_ready(rdy_x), .in_word(in_word),
    .out_valid(ov_x), .out_ready(out_ready), .out_pixel(px_x), .out_is_index(ix_x));

  function automatic int width_of(input bit ext, input int code);
    int c;
    c = (!ext && code >= 6) ? 4 : code;
    case (c)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      5: return 32;
      default: return 16;
    endcase
  endfunction

  // returns {is_index, pixel}
  function automatic logic [24:0] model(input bit ext, input int code, input bit beb,
                                        input bit bep, input bit bgr, input int mux,
                                        input logic [31:0] w, input int i);
    int c, b, n, j, per, rw, gw, bw;
    bit sw;
    longint v, r, g, bl;
    c = (!ext && code >= 6) ? 4 : code;
    b = width_of(ext, code);
    n = 32 / b;
    if (beb) j = n - 1 - i;
    else if (bep && b < 8) begin
      per = 8 / b;
      j = (i / per) * per + (per - 1 - (i % per));
    end else j = i;
    v = (longint'(w) >> (j * b)) % (longint'(1) << b);
    if (c <= 3) return {1'b1, 16'b0, 8'(v)};
    sw = bgr;
    if (c == 5)      begin rw = 8; gw = 8; bw = 8; end
    else if (c == 7) begin rw = 4; gw = 4; bw = 4; end
    else if (c == 6) begin rw = 5; gw = 6; bw = 5; end
    else if (ext || mux == 1) begin rw = 5; gw = 5; bw = 5; end
    else begin
      rw = 5; gw = 6; bw = 5;
      if (mux == 3) sw = 1'b1;
    end
    r  = (v % (longint'(1) << rw)) << (8 - rw);
    g  = ((v >> rw) % (longint'(1) << gw)) << (8 - gw);
    bl = ((v >> (rw + gw)) % (longint'(1) << bw)) << (8 - bw);
    if (sw) return {1'b0, 8'(bl), 8'(g), 8'(r)};
    return {1'b0, 8'(r), 8'(g), 8'(bl)};
  endfunction

  function automatic string tag_of(input bit ext, input int code, input bit beb,
                                   input bit bep, input bit bgr);
    if (!ext && code == 4) return "R10";
    if (code >= 6) return "R11";
    if (code > 3 && bgr) return "R9";
    if (code > 3) return "R8";
    if (beb) return "R5";
    if (bep) return "R6";
    return "R4";
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    applied++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    int n;
    logic [24:0] eb, ex;
    n = 32 / width_of(1'b0, int'(cfg_depth));
    @(negedge clk);
    check("R2", "in_ready idle", longint'(rdy_b & rdy_x), 1);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = ~w;
    for (int i = 0; i < n; i++) begin
      eb = model(1'b0, int'(cfg_depth), cfg_be_byte, cfg_be_pix, cfg_bgr, int'(fmt_mux), w, i);
      ex = model(1'b1, int'(cfg_depth), cfg_be_byte, cfg_be_pix, cfg_bgr, int'(fmt_mux), w, i);
      check("R2", "out_valid", longint'({ov_b, ov_x, rdy_b}), 64'h6);
      check(tag_of(1'b0, int'(cfg_depth), cfg_be_byte, cfg_be_pix, cfg_bgr), "base pixel",
            longint'({ix_b, px_b}), longint'(eb));
      check(tag_of(1'b1, int'(cfg_depth), cfg_be_byte, cfg_be_pix, cfg_bgr), "ext pixel",
            longint'({ix_x, px_x}), longint'(ex));
      @(negedge clk);
    end
    // R3: word exhausted after exactly 32/width pixels
    check("R3", "word end", longint'({ov_b, ov_x, rdy_b, rdy_x}), 64'h3);
  endtask

  function automatic longint exp_lb(input bit ext, input int code, input int w);
    case (ext || code < 6 ? code : 4)
      0: return w / 8;
      1: return w / 4;
      2: return w / 2;
      3: return w;
      5: return w * 4;
      default: return w * 2;
    endcase
  endfunction

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin : stim
    logic [31:0] w;
    logic [24:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset out_valid", longint'({ov_b, ov_x}), 0);
    check("R1", "reset in_ready", longint'({rdy_b, rdy_x}), 3);
    rst_n = 1'b1;

    // R12: line bytes for all codes
    foreach (cfg_width[k]) ;
    for (int wi = 0; wi < 3; wi++) begin
      for (int c = 0; c < 8; c++) begin
        cfg_width = (wi == 0) ? 12'd320 : (wi == 1) ? 12'd4095 : 12'd13;
        cfg_depth = 3'(c);
        #1;
        check("R12", "base line_bytes", longint'(lb_b), exp_lb(1'b0, c, int'(cfg_width)));
        check("R12", "ext line_bytes", longint'(lb_x), exp_lb(1'b1, c, int'(cfg_width)));
      end
    end

    // R2: stall holds the pixel
    cfg_depth = 3'd3; cfg_be_byte = 1'b0; cfg_be_pix = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_word = 32'hC4B3_A291;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    held = {ix_b, px_b};
    check("R2", "first pixel", longint'(held), longint'({1'b1, 24'h91}));
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      check("R2", "stall hold", longint'({ov_b, ix_b, px_b}), longint'({1'b1, held}));
      check("R2", "stall no take", longint'(rdy_b), 0);
    end
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    check("R2", "stall end", longint'({ov_b, rdy_b}), 1);

    // sweep: depth x ordering x swap x mux x words; R7 indices on codes 0-3
    for (int c = 0; c < 8; c++)
      for (int o = 0; o < 4; o++)
        for (int s = 0; s < 2; s++)
          for (int m = 0; m < 4; m++)
            for (int k = 0; k < 2; k++) begin
              cfg_depth   = 3'(c);
              cfg_be_byte = o[1];
              cfg_be_pix  = o[0];
              cfg_bgr     = s[0];
              fmt_mux     = 2'(m);
              w = 32'hA5C3_1E97 ^ (32'(k + m * 2 + c * 8) * 32'h9E37_79B9);
              send_word(w);
            end

    $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule